// File: doc/BRIEF.md
# Free-Running Time Base with Compare Interrupt

This block keeps a 56-bit count that advances by one on every clock cycle in which a tick input is high. Software reaches the count and a single compare stage through a simple register port. Each access takes one cycle and is made of an address, a write strobe, a read strobe, write data and combinational read data. The count cannot be written. It starts from a reset value set by a parameter, and it wraps to zero after the all-ones value.

The count is exposed as two 32-bit words. A read of the low word also copies the upper 24 bits of the count into a holding register. A later read of the high word returns that held copy. Reading the low word first and then the high word therefore always gives a consistent 56-bit value, even when a carry crosses from the low word into the high word between the two reads.

The compare stage holds a 56-bit threshold and a control word. When enabled, it sets a status flag once the count is equal to or above the threshold, and it drives a level interrupt from that flag unless the interrupt is masked. The only way to acknowledge the interrupt is to write the enable bit to zero.

Top module: `sysctr_top`

## Requirements
- R1: After reset the count equals the parameter CNT_INIT. It then rises by exactly one after each clock edge at which tick_i is high, and holds after each edge at which tick_i is low.
- R2: The count wraps from all ones to zero, with no effect on the rest of the block.
- R3: A read of offset 0x8 returns count bits 31:0. On the edge that ends that read, count bits 55:32 are copied into a holding register. A read of offset 0xC returns the holding register, zero-extended to 32 bits.
- R4: Offset 0x10020 holds threshold bits 31:0. Offset 0x10024 holds threshold bits 55:32: only 24 bits are stored, and bits 31:24 read as zero. Both registers are read/write and reset to zero.
- R5: The control word at offset 0x1002C has enable at bit 0 and interrupt mask at bit 1, both read/write. The status flag is at bit 2 and is read-only. All other bits read as zero.
- R6: If enable is 1 and the count is equal to or above the threshold (unsigned 56-bit compare), status is set at the next edge. A control write that sets enable while the count is already at or past the threshold sets status at the edge of that same write.
- R7: Once set, status stays set while enable remains 1, whatever the count or threshold does afterwards.
- R8: A control write with bit 0 equal to 0 clears status at the edge of that write. This write also wins over a threshold hit in the same cycle.
- R9: irq_o is active high and level: it equals status while the mask is 0 and is 0 while the mask is 1. The mask never changes status. status_o always shows the status flag.
- R10: After reset, status, enable, mask and irq_o are 0, and all readable registers except the count read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count advance enable |
| addr_i | input | 17 | Register byte offset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe; a read of the low count word updates the holding register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| irq_o | output | 1 | Level interrupt, active high |
| status_o | output | 1 | Compare status flag |

## Verification
Two events can fall in the same cycle: the acknowledge write that clears enable, and the threshold being reached. The bench sets the threshold one above a frozen count and enables the stage. It then gives exactly one tick, so the count reaches the threshold on that edge, and places the enable-clear write in the very next cycle, where the hit would otherwise set status. Status and irq_o must stay low. A later enable must then set status at once, because the count already sits at the threshold.

// File: rtl/sysctr_pkg.sv
package sysctr_pkg;
  localparam int unsigned OFF_CNT_LO = 32'h0000_0008;
  localparam int unsigned OFF_CNT_HI = 32'h0000_000C;
  localparam int unsigned OFF_CMP_LO = 32'h0001_0020;
  localparam int unsigned OFF_CMP_HI = 32'h0001_0024;
  localparam int unsigned OFF_CTRL   = 32'h0001_002C;
  localparam int unsigned BIT_EN     = 0;
  localparam int unsigned BIT_MASK   = 1;
  localparam int unsigned BIT_STAT   = 2;

  typedef struct packed {
    logic we_cmp_lo;
    logic we_cmp_hi;
    logic we_ctrl;
    logic rd_cnt_lo;
  } strobe_t;
endpackage

// File: rtl/sysctr_counter.sv
module sysctr_counter #(
  parameter int unsigned CNT_W = 56,
  parameter logic [CNT_W-1:0] CNT_INIT = '0,
  localparam int unsigned HI_W = CNT_W - 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             snap_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [HI_W-1:0]  shadow_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [HI_W-1:0]  shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CNT_INIT;
    end else if (tick_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // high half held at low-word read for tear-free access
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
    end else if (snap_i) begin
      shadow_q <= cnt_q[CNT_W-1:32];
    end
  end

  assign cnt_o    = cnt_q;
  assign shadow_o = shadow_q;
endmodule

// File: rtl/sysctr_compare.sv
module sysctr_compare
  import sysctr_pkg::*;
#(
  parameter int unsigned CNT_W = 56,
  localparam int unsigned HI_W = CNT_W - 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  strobe_t          stb_i,
  input  logic [31:0]      wdata_i,
  output logic [CNT_W-1:0] cmp_o,
  output logic             en_o,
  output logic             mask_o,
  output logic             status_o
);
  logic [31:0]   lo_q;
  logic [HI_W-1:0] hi_q;
  logic en_q, mask_q, stat_q;
  logic en_d, hit;

  assign cmp_o = {hi_q, lo_q};
  assign hit   = (cnt_i >= cmp_o);
  assign en_d  = stb_i.we_ctrl ? wdata_i[BIT_EN] : en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      hi_q   <= '0;
      en_q   <= 1'b0;
      mask_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      if (stb_i.we_cmp_lo) lo_q <= wdata_i;
      if (stb_i.we_cmp_hi) hi_q <= wdata_i[HI_W-1:0];
      if (stb_i.we_ctrl)   mask_q <= wdata_i[BIT_MASK];
      en_q   <= en_d;
      // clearing enable is the only acknowledge and beats a same-cycle hit
      stat_q <= en_d & (stat_q | hit);
    end
  end

  assign en_o     = en_q;
  assign mask_o   = mask_q;
  assign status_o = stat_q;
endmodule

// File: rtl/sysctr_regs.sv
module sysctr_regs
  import sysctr_pkg::*;
#(
  parameter int unsigned CNT_W  = 56,
  parameter int unsigned ADDR_W = 17,
  localparam int unsigned HI_W  = CNT_W - 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [HI_W-1:0]   shadow_i,
  input  logic [CNT_W-1:0]  cmp_i,
  input  logic              en_i,
  input  logic              mask_i,
  input  logic              status_i,
  output strobe_t           stb_o,
  output logic [31:0]       rdata_o
);
  logic sel_cnt_lo, sel_cnt_hi, sel_cmp_lo, sel_cmp_hi, sel_ctrl;

  assign sel_cnt_lo = (addr_i == ADDR_W'(OFF_CNT_LO));
  assign sel_cnt_hi = (addr_i == ADDR_W'(OFF_CNT_HI));
  assign sel_cmp_lo = (addr_i == ADDR_W'(OFF_CMP_LO));
  assign sel_cmp_hi = (addr_i == ADDR_W'(OFF_CMP_HI));
  assign sel_ctrl   = (addr_i == ADDR_W'(OFF_CTRL));

  always_comb begin
    stb_o.we_cmp_lo = wr_en_i & sel_cmp_lo;
    stb_o.we_cmp_hi = wr_en_i & sel_cmp_hi;
    stb_o.we_ctrl   = wr_en_i & sel_ctrl;
    stb_o.rd_cnt_lo = rd_en_i & sel_cnt_lo;
  end

  always_comb begin
    rdata_o = '0;
    if (sel_cnt_lo)      rdata_o = cnt_i[31:0];
    else if (sel_cnt_hi) rdata_o = 32'(shadow_i);
    else if (sel_cmp_lo) rdata_o = cmp_i[31:0];
    else if (sel_cmp_hi) rdata_o = 32'(cmp_i[CNT_W-1:32]);
    else if (sel_ctrl) begin
      rdata_o[BIT_EN]   = en_i;
      rdata_o[BIT_MASK] = mask_i;
      rdata_o[BIT_STAT] = status_i;
    end
  end
endmodule

// File: rtl/sysctr_top.sv
module sysctr_top
  import sysctr_pkg::*;
#(
  parameter int unsigned CNT_W  = 56,
  parameter int unsigned ADDR_W = 17,
  parameter logic [CNT_W-1:0] CNT_INIT = '0,
  localparam int unsigned HI_W  = CNT_W - 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  output logic              status_o
);
  strobe_t          stb;
  logic [CNT_W-1:0] cnt_w, cmp_w;
  logic [HI_W-1:0]  shadow_w;
  logic             en_w, mask_w, stat_w;

  sysctr_counter #(.CNT_W(CNT_W), .CNT_INIT(CNT_INIT)) u_cnt (
    .clk_i, .rst_ni, .tick_i,
    .snap_i  (stb.rd_cnt_lo),
    .cnt_o   (cnt_w),
    .shadow_o(shadow_w)
  );

  sysctr_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk_i, .rst_ni,
    .cnt_i   (cnt_w),
    .stb_i   (stb),
    .wdata_i,
    .cmp_o   (cmp_w),
    .en_o    (en_w),
    .mask_o  (mask_w),
    .status_o(stat_w)
  );

  sysctr_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .addr_i, .wr_en_i, .rd_en_i,
    .cnt_i   (cnt_w),
    .shadow_i(shadow_w),
    .cmp_i   (cmp_w),
    .en_i    (en_w),
    .mask_i  (mask_w),
    .status_i(stat_w),
    .stb_o   (stb),
    .rdata_o
  );

  assign irq_o    = stat_w & ~mask_w;
  assign status_o = stat_w;
endmodule

// File: rtl/sysctr_chk.sv
module sysctr_chk
  import sysctr_pkg::*;
#(
  parameter int unsigned CNT_W  = 56,
  parameter int unsigned ADDR_W = 17
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [CNT_W-33:0] shadow_i,
  input logic [CNT_W-1:0]  cmp_i,
  input logic              en_i,
  input logic              mask_i,
  input logic              status_i,
  input logic              irq_i
);
  logic ack, snap;
  assign ack  = wr_en_i && (addr_i == ADDR_W'(OFF_CTRL)) && !wdata_i[BIT_EN];
  assign snap = rd_en_i && (addr_i == ADDR_W'(OFF_CNT_LO));

  p_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> cnt_i == $past(cnt_i) + CNT_W'(1));
  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_i));
  p_shadow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap |=> shadow_i == $past(cnt_i[CNT_W-1:32]));
  p_fire_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (cnt_i >= cmp_i) && !ack) |=> status_i);
  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i && !ack) |=> status_i);
  p_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack |=> !status_i);
  p_irq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (status_i && !mask_i));
  p_stat_en_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i |-> en_i);
endmodule

bind sysctr_top sysctr_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
  .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i), .cnt_i(cnt_w),
  .shadow_i(shadow_w), .cmp_i(cmp_w), .en_i(en_w), .mask_i(mask_w),
  .status_i(stat_w), .irq_i(irq_o)
);

// File: tb/tb_sysctr_top.sv
`timescale 1ns/1ps
module tb_sysctr_top;
  localparam int unsigned CNT_W = 56;
  localparam logic [CNT_W-1:0] INIT = 56'hFF_FFFF_FFFF_FFC0;
  localparam logic [16:0] A_CLO = 17'h00008, A_CHI = 17'h0000C,
                          A_PLO = 17'h10020, A_PHI = 17'h10024, A_CTL = 17'h1002C;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [16:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq, status;
  logic [CNT_W-1:0] exp_cnt;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  sysctr_top #(.CNT_W(CNT_W), .ADDR_W(17), .CNT_INIT(INIT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .addr_i(addr), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .status_o(status)
  );

  // reference count per R1/R2
  always @(posedge clk or negedge rst_n)
    if (!rst_n) exp_cnt <= INIT;
    else if (tick) exp_cnt <= exp_cnt + 56'd1;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [16:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [16:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #2 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic set_cmp(input logic [CNT_W-1:0] v);
    wr(A_PLO, v[31:0]);
    wr(A_PHI, 32'(v[55:32]));
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R10 status", status, 0); check("R10 irq", irq, 0);
    rd(A_CLO, d); check("R1 init lo", d, INIT[31:0]);
    rd(A_CHI, d); check("R3 init hi", d, 32'(INIT[55:32]));
    rd(A_CTL, d); check("R10 ctrl", d, 0);
    rd(A_PLO, d); check("R10 cmp lo", d, 0);
    rd(A_PHI, d); check("R10 cmp hi", d, 0);
  endtask

  task automatic t_count;
    logic [31:0] d;
    ticks(10);
    rd(A_CLO, d); check("R1 count lo", d, 32'(INIT + 56'd10));
    rd(A_CHI, d); check("R1 count hi", d, 32'(INIT[55:32]));
    repeat (5) @(negedge clk);
    rd(A_CLO, d); check("R1 hold", d, 32'(INIT + 56'd10));
  endtask

  task automatic t_shadow;
    logic [31:0] d, hi_exp;
    @(negedge clk); tick = 1'b1;
    @(negedge clk); addr = A_CLO; rd_en = 1'b1;
    #2 d = rdata; hi_exp = 32'(exp_cnt[55:32]);
    check("R3 live lo", d, exp_cnt[31:0]);
    @(negedge clk); rd_en = 1'b0;
    repeat (60) @(negedge clk);
    rd(A_CHI, d); check("R3 held hi across carry", d, hi_exp);
    tick = 1'b0;
    rd(A_CLO, d); check("R2 wrapped lo", d, exp_cnt[31:0]);
    check("R2 wrapped small", 64'(d < 32'd100), 1);
    rd(A_CHI, d); check("R2 wrapped hi", d, 0);
  endtask

  task automatic t_cmp_regs;
    logic [31:0] d;
    wr(A_PHI, 32'hFFFF_FFFF); rd(A_PHI, d); check("R4 hi width", d, 32'h00FF_FFFF);
    wr(A_PLO, 32'hA5A5_5A5A); rd(A_PLO, d); check("R4 lo", d, 32'hA5A5_5A5A);
    wr(A_CTL, 32'hFFFF_FFFA); rd(A_CTL, d); check("R5 ctrl bits", d, 32'h2);
    wr(A_CTL, 0);
  endtask

  task automatic t_fire;
    logic [31:0] d;
    logic [CNT_W-1:0] e;
    e = exp_cnt;
    set_cmp(e + 56'd5);
    wr(A_CTL, 1); check("R6 below", status, 0);
    ticks(4); @(negedge clk); check("R6 one short", status, 0);
    ticks(1); check("R6 edge of equal", status, 0);
    @(negedge clk); check("R6 set", status, 1); check("R9 irq", irq, 1);
    rd(A_CTL, d); check("R5 status bit", d, 32'h5);
    ticks(3); check("R7 past cmp", status, 1);
    set_cmp('1); check("R7 cmp raised", status, 1); check("R7 irq", irq, 1);
    wr(A_CTL, 0); check("R8 ack", status, 0); check("R8 irq", irq, 0);
    repeat (3) @(negedge clk); check("R8 stays clear", status, 0);
  endtask

  task automatic t_past_mask;
    logic [31:0] d;
    set_cmp(exp_cnt - 56'd3);
    wr(A_CTL, 1); check("R6 already passed", status, 1);
    wr(A_CTL, 3); check("R9 masked irq", irq, 0); check("R9 status kept", status, 1);
    rd(A_CTL, d); check("R9 ctrl", d, 32'h7);
    wr(A_CTL, 1); check("R9 unmasked", irq, 1);
    wr(A_CTL, 2); check("R8 ack while masked", status, 0);
    wr(A_CTL, 0);
  endtask

  task automatic t_collide;
    set_cmp(exp_cnt + 56'd1);
    wr(A_CTL, 1); check("R6 not yet", status, 0);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0; addr = A_CTL; wdata = 0; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    check("R8 ack beats hit", status, 0); check("R8 irq low", irq, 0);
    @(negedge clk); check("R8 still clear", status, 0);
    wr(A_CTL, 1); check("R6 enable at hit", status, 1);
    wr(A_CTL, 0);
  endtask

  task automatic t_unsigned;
    set_cmp('1);
    wr(A_CTL, 1);
    ticks(5); @(negedge clk);
    check("R6 unsigned no fire", status, 0); check("R9 no irq", irq, 0);
    wr(A_CTL, 0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_count;
    t_shadow;
    t_cmp_regs;
    t_fire;
    t_past_mask;
    t_collide;
    t_unsigned;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule